// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the configuration header of one PCI endpoint. Its capability area sits in the same register file. A single configuration port serves it. Each request carries a byte offset, an access size of 1, 2 or 4 bytes, a write flag and write data. The block answers every request one cycle later with an acknowledge, an error flag and read data.

Reads of a narrow width are served from the containing dword, shifted and masked. The identity, class and subsystem fields are fixed by parameters. The command register and the interrupt-line byte are writable. Base-address contents come from external address-window units, and 32-bit writes to present slots are forwarded to those units as a one-cycle strobe.

A side port appends capability dwords to an internal store mapped at offsets 0xA4 to 0xFF. As each record is appended, the block links it into the capability chain. The block also gates an incoming pending-interrupt level with the interrupt-disable bit of the command register.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: Every request on `cfg_req` is answered by `cfg_ack` exactly one cycle later. There is no acknowledge without a request.
- R2: An access whose size is not 1, 2 or 4 is refused: `cfg_err`=1, `cfg_rdata`=0 and no state changes. The same holds for an access whose offset is not a multiple of its size.
- R3: A read returns the dword at offset[7:2], shifted right by offset[1:0]×8 and masked to the access width.
- R4: Dword 0x00 reads {DEVICE_ID, VENDOR_ID}, 0x08 reads {CLASS_CODE, 8'h00}, 0x0C reads 0, and 0x2C reads {SUBSYS_ID, SUBSYS_VID}.
- R5: The command register (0x04, bits 15:0) resets to 0x0003. It is written only by a 2-byte write at offset 0x04. Any other write size at 0x04 is refused with `cfg_err`.
- R6: Status (0x04, bits 31:16) always has bit 3 (interrupt status) set. Bit 4 (capability list) is set only while at least one capability dword is stored.
- R7: Dword 0x3C reads the interrupt pin fixed at 1 in bits 15:8 and the interrupt line in bits 7:0. The line is loaded from wdata[7:0] by a write at offset 0x3C of any legal size. A write at offset 0x3D is ignored.
- R8: Dwords 0x10..0x24 are base-address slots 0..5. A slot below BAR_SLOTS reads `bar_words[32*slot +: 32]`, and a slot at or above BAR_SLOTS reads 0. A 4-byte write to a present slot pulses `bar_wr` with `bar_wr_slot` and `bar_wr_data` in the acknowledge cycle. A 4-byte write to an absent slot completes without a pulse. Other sizes at a slot offset are refused.
- R9: Dword 0x34 reads 0xA4 when capabilities are stored and 0 otherwise.
- R10: `cap_push` appends one dword; `cap_first` (or an empty store) starts a new record. A record start has its byte 1 (next pointer) forced to 0. The start of the previous record gets its next pointer patched to 0xA4 + 4×(new index). Capability reads past the filled dwords return 0. Pushes into a full store (23 dwords) are ignored, including any patch.
- R11: Reads of reserved offsets return 0. Writes to them complete without error and change nothing.
- R12: `irq_req` equals `irq_pending` AND NOT command bit 10, evaluated from the current command value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration request valid |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 8 | Byte offset in the header |
| cfg_size | input | 3 | Access size in bytes (1, 2, 4) |
| cfg_wdata | input | 32 | Write data, right-aligned |
| cfg_ack | output | 1 | Response valid, one cycle after request |
| cfg_err | output | 1 | Request refused |
| cfg_rdata | output | 32 | Read data, right-aligned |
| bar_words | input | 192 | Current contents of base-address slots 0..5 |
| bar_wr | output | 1 | Base-address slot write strobe |
| bar_wr_slot | output | 3 | Slot being written |
| bar_wr_data | output | 32 | Data for the slot write |
| cap_push | input | 1 | Append one capability dword |
| cap_first | input | 1 | Pushed dword starts a new record |
| cap_data | input | 32 | Capability dword |
| irq_pending | input | 1 | Device has an interrupt pending |
| irq_req | output | 1 | Interrupt request toward the bus |

## Verification
All configuration results (acknowledge, error, read data and the base-address write strobe) appear in the cycle after the request edge. The bench raises a request at a falling edge, lets one rising edge pass, and samples at the following falling edge. Register and capability updates take effect at that same edge, so the very next request already sees them. `irq_req` is combinational on the stored command, and the bench samples it one falling edge after the command write.

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile #(
  parameter logic [15:0] VENDOR_ID  = 16'h1B36,
  parameter logic [15:0] DEVICE_ID  = 16'h0010,
  parameter logic [15:0] SUBSYS_VID = 16'h1AF4,
  parameter logic [15:0] SUBSYS_ID  = 16'h1100,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter int          BAR_SLOTS  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_req,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_off,
  input  logic [2:0]   cfg_size,
  input  logic [31:0]  cfg_wdata,
  output logic         cfg_ack,
  output logic         cfg_err,
  output logic [31:0]  cfg_rdata,
  input  logic [191:0] bar_words,
  output logic         bar_wr,
  output logic [2:0]   bar_wr_slot,
  output logic [31:0]  bar_wr_data,
  input  logic         cap_push,
  input  logic         cap_first,
  input  logic [31:0]  cap_data,
  input  logic         irq_pending,
  output logic         irq_req
);
  localparam int CAP_DW = 23;
  localparam int CNT_W  = $clog2(CAP_DW + 1);
  localparam logic [CNT_W-1:0] CAP_LIM = CNT_W'(CAP_DW);
  localparam logic [2:0] NBAR = 3'(BAR_SLOTS);
  localparam logic [5:0] CAP_DWI = 6'd41;

  logic [15:0] cmd_q;
  logic [7:0]  line_q;
  logic [31:0] cap_mem [CAP_DW];
  logic [CNT_W-1:0] cap_cnt, last_start;

  logic [5:0] dwi;
  logic [2:0] slot;
  logic [CNT_W-1:0] cap_idx;
  logic size_ok, misal, bad, is_bar, wr_refuse;
  logic [31:0] word, shifted, mask;
  logic [15:0] status;
  logic has_caps;

  assign dwi      = cfg_off[7:2];
  assign slot     = 3'(dwi - 6'd4);
  assign cap_idx  = CNT_W'(dwi - CAP_DWI);
  assign has_caps = cap_cnt != '0;
  assign status   = {11'd0, has_caps, 1'b1, 3'd0};
  assign size_ok  = (cfg_size == 3'd1) || (cfg_size == 3'd2) || (cfg_size == 3'd4);
  assign misal    = ((cfg_size == 3'd2) && cfg_off[0]) ||
                    ((cfg_size == 3'd4) && (cfg_off[1:0] != 2'b00));
  assign bad      = !size_ok || misal;
  assign is_bar   = (dwi >= 6'd4) && (dwi <= 6'd9);
  assign irq_req  = irq_pending && !cmd_q[10];

  always_comb begin
    word = 32'd0;
    if (is_bar) begin
      if (slot < NBAR) word = bar_words[32*slot +: 32];
    end else if (dwi >= CAP_DWI) begin
      if (cap_idx < cap_cnt) word = cap_mem[cap_idx];
    end else begin
      case (dwi)
        6'd0:    word = {DEVICE_ID, VENDOR_ID};
        6'd1:    word = {status, cmd_q};
        6'd2:    word = {CLASS_CODE, 8'h00};
        6'd11:   word = {SUBSYS_ID, SUBSYS_VID};
        6'd13:   word = has_caps ? 32'h0000_00A4 : 32'd0;
        6'd15:   word = {16'd0, 8'h01, line_q};
        default: word = 32'd0;
      endcase
    end
  end

  assign shifted = word >> {cfg_off[1:0], 3'b000};
  assign mask    = (cfg_size == 3'd1) ? 32'h0000_00FF :
                   (cfg_size == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  always_comb begin
    wr_refuse = 1'b0;
    if (cfg_off == 8'h04 && cfg_size != 3'd2) wr_refuse = 1'b1;
    if (is_bar && cfg_off[1:0] == 2'b00 && cfg_size != 3'd4) wr_refuse = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ack     <= 1'b0;
      cfg_err     <= 1'b0;
      cfg_rdata   <= 32'd0;
      bar_wr      <= 1'b0;
      bar_wr_slot <= 3'd0;
      bar_wr_data <= 32'd0;
      cmd_q       <= 16'h0003;
      line_q      <= 8'h00;
    end else begin
      cfg_ack   <= cfg_req;
      cfg_err   <= 1'b0;
      cfg_rdata <= 32'd0;
      bar_wr    <= 1'b0;
      if (cfg_req) begin
        if (bad) begin
          cfg_err <= 1'b1;
        end else if (!cfg_we) begin
          cfg_rdata <= shifted & mask;
        end else if (wr_refuse) begin
          cfg_err <= 1'b1;
        end else begin
          if (cfg_off == 8'h04) cmd_q <= cfg_wdata[15:0];
          if (cfg_off == 8'h3C) line_q <= cfg_wdata[7:0];
          if (is_bar && cfg_off[1:0] == 2'b00 && slot < NBAR) begin
            bar_wr      <= 1'b1;
            bar_wr_slot <= slot;
            bar_wr_data <= cfg_wdata;
          end
        end
      end
    end
  end

  logic cap_take, cap_new;
  assign cap_take = cap_push && (cap_cnt < CAP_LIM);
  assign cap_new  = cap_first || !has_caps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cnt    <= '0;
      last_start <= '0;
      for (int i = 0; i < CAP_DW; i++) cap_mem[i] <= 32'd0;
    end else if (cap_take) begin
      cap_cnt <= cap_cnt + 1'b1;
      if (cap_new) begin
        cap_mem[cap_cnt] <= {cap_data[31:16], 8'h00, cap_data[7:0]};
        last_start       <= cap_cnt;
        if (has_caps)
          cap_mem[last_start][15:8] <= 8'hA4 + {1'b0, 7'({cap_cnt, 2'b00})};
      end else begin
        cap_mem[cap_cnt] <= cap_data;
      end
    end
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> cfg_ack); // R1
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |=> !cfg_ack); // R1
  AST_ODD_HALF_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_size == 3'd2 && cfg_off[0]) |=> (cfg_err && cfg_rdata == 32'd0)); // R2
  AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && cfg_we) |=> $stable(cmd_q)); // R5
  AST_BAR_WR_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr |-> ($past(cfg_size) == 3'd4 && $past(cfg_we))); // R8
  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cap_cnt <= CAP_LIM); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_pending && !cmd_q[10])); // R12
endmodule

// File: tb/cfg_hdr_regfile_tb.sv
module cfg_hdr_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_req = 0, cfg_we = 0;
  logic [7:0] cfg_off = 0;
  logic [2:0] cfg_size = 0;
  logic [31:0] cfg_wdata = 0;
  logic cfg_ack, cfg_err, bar_wr;
  logic [31:0] cfg_rdata, bar_wr_data;
  logic [2:0] bar_wr_slot;
  logic cap_push = 0, cap_first = 0;
  logic [31:0] cap_data = 0;
  logic irq_pending = 0, irq_req;
  logic [191:0] bar_words;

  assign bar_words = {32'hC0DE_0005, 32'hC0DE_0004, 32'hC0DE_0003,
                      32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};

  cfg_hdr_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .cfg_rdata(cfg_rdata), .bar_words(bar_words), .bar_wr(bar_wr), .bar_wr_slot(bar_wr_slot),
    .bar_wr_data(bar_wr_data), .cap_push(cap_push), .cap_first(cap_first), .cap_data(cap_data),
    .irq_pending(irq_pending), .irq_req(irq_req));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic r_ack, r_err, r_bw;
  logic [31:0] r_data, r_bdata;
  logic [2:0] r_bslot;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    cfg_req = 1; cfg_we = we; cfg_off = off; cfg_size = sz; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
    r_ack = cfg_ack; r_err = cfg_err; r_data = cfg_rdata;
    r_bw = bar_wr; r_bslot = bar_wr_slot; r_bdata = bar_wr_data;
  endtask

  task automatic rd(input string tag, input logic [7:0] off, input logic [2:0] sz,
                    input logic [31:0] exp);
    access(0, off, sz, 0);
    chk({tag, " ack"}, {31'd0, r_ack}, 1);
    chk({tag, " err"}, {31'd0, r_err}, 0);
    chk(tag, r_data, exp);
  endtask

  task automatic push(input logic first, input logic [31:0] d);
    @(negedge clk);
    cap_push = 1; cap_first = first; cap_data = d;
    @(negedge clk);
    cap_push = 0; cap_first = 0;
  endtask

  task automatic t_reset;
    chk("R1 no ack at reset", {31'd0, cfg_ack}, 0);
    chk("R12 irq idle at reset", {31'd0, irq_req}, 0);
    rd("R5 R6 cmd/status reset", 8'h04, 4, 32'h0008_0003);
  endtask

  task automatic t_ident;
    rd("R4 ids", 8'h00, 4, 32'h0010_1B36);
    rd("R3 hi half", 8'h02, 2, 32'h0000_0010);
    rd("R3 byte1", 8'h01, 1, 32'h0000_001B);
    rd("R4 class", 8'h08, 4, 32'h0200_0000);
    rd("R4 header type", 8'h0C, 4, 32'h0);
    rd("R4 subsystem", 8'h2C, 4, 32'h1100_1AF4);
    rd("R3 subsys byte3", 8'h2F, 1, 32'h0000_0011);
  endtask

  task automatic t_refuse;
    access(0, 8'h02, 4, 0);
    chk("R2 misaligned err", {31'd0, r_err}, 1);
    chk("R2 misaligned data", r_data, 0);
    access(1, 8'h3D, 2, 32'hFF);
    chk("R2 odd half write err", {31'd0, r_err}, 1);
    access(0, 8'h00, 3, 0);
    chk("R2 size3 err", {31'd0, r_err}, 1);
    chk("R1 ack on refused", {31'd0, r_ack}, 1);
    rd("R2 line untouched", 8'h3C, 4, 32'h0000_0100);
  endtask

  task automatic t_cmd_irq;
    irq_pending = 1;
    @(negedge clk);
    chk("R12 irq when enabled", {31'd0, irq_req}, 1);
    access(1, 8'h04, 2, 32'h0000_0407);
    chk("R5 cmd write ok", {31'd0, r_err}, 0);
    chk("R12 irq masked", {31'd0, irq_req}, 0);
    rd("R5 cmd readback", 8'h04, 2, 32'h0000_0407);
    access(1, 8'h04, 4, 32'h0000_0000);
    chk("R5 wide cmd refused", {31'd0, r_err}, 1);
    rd("R5 cmd kept", 8'h04, 2, 32'h0000_0407);
    access(1, 8'h04, 2, 32'h0000_0003);
    chk("R12 irq restored", {31'd0, irq_req}, 1);
    irq_pending = 0;
    @(negedge clk);
    chk("R12 irq no pending", {31'd0, irq_req}, 0);
  endtask

  task automatic t_line;
    access(1, 8'h3C, 1, 32'h0000_00AB);
    chk("R7 line write ok", {31'd0, r_err}, 0);
    rd("R7 line/pin", 8'h3C, 4, 32'h0000_01AB);
    rd("R7 pin byte", 8'h3D, 1, 32'h0000_0001);
    access(1, 8'h3D, 1, 32'h0000_0055);
    rd("R7 pin not writable", 8'h3C, 4, 32'h0000_01AB);
  endtask

  task automatic t_bar;
    rd("R8 slot0", 8'h10, 4, 32'hC0DE_0000);
    rd("R8 slot1", 8'h14, 4, 32'hC0DE_0001);
    rd("R8 absent slot2", 8'h18, 4, 32'h0);
    rd("R8 slot1 hi half", 8'h16, 2, 32'h0000_C0DE);
    access(1, 8'h14, 4, 32'hFEED_0000);
    chk("R8 strobe", {31'd0, r_bw}, 1);
    chk("R8 strobe slot", {29'd0, r_bslot}, 1);
    chk("R8 strobe data", r_bdata, 32'hFEED_0000);
    access(1, 8'h18, 4, 32'h1234_0000);
    chk("R8 absent no strobe", {31'd0, r_bw}, 0);
    chk("R8 absent no err", {31'd0, r_err}, 0);
    access(1, 8'h10, 2, 32'h1);
    chk("R8 half write refused", {31'd0, r_err}, 1);
    chk("R8 half write no strobe", {31'd0, r_bw}, 0);
  endtask

  task automatic t_reserved;
    rd("R11 reserved read", 8'h40, 4, 32'h0);
    access(1, 8'h40, 4, 32'hFFFF_FFFF);
    chk("R11 reserved write no err", {31'd0, r_err}, 0);
    rd("R11 reserved still 0", 8'h40, 4, 32'h0);
    rd("R9 no cap ptr", 8'h34, 4, 32'h0);
    rd("R10 empty cap area", 8'hA4, 4, 32'h0);
  endtask

  task automatic t_caps;
    push(1, 32'hDEAD_FF05);
    push(0, 32'h1234_5678);
    rd("R10 first rec next=0", 8'hA4, 4, 32'hDEAD_0005);
    rd("R9 cap ptr", 8'h34, 4, 32'h0000_00A4);
    rd("R6 status caps bit", 8'h06, 2, 32'h0000_0018);
    push(1, 32'hBEEF_7709);
    rd("R10 patched next", 8'hA4, 4, 32'hDEAD_AC05);
    rd("R10 patched byte", 8'hA5, 1, 32'h0000_00AC);
    rd("R10 second rec", 8'hAC, 4, 32'hBEEF_0009);
    rd("R10 body dword", 8'hA8, 4, 32'h1234_5678);
    rd("R10 past fill", 8'hB0, 4, 32'h0);
    for (int k = 0; k < 20; k++) push(0, 32'h5000_0000 + k);
    rd("R10 last slot", 8'hFC, 4, 32'h5000_0013);
    push(1, 32'h0000_0A11);
    rd("R10 full ignores patch", 8'hAC, 4, 32'hBEEF_0009);
    rd("R10 full keeps last", 8'hFC, 4, 32'h5000_0013);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ident();
    t_refuse();
    t_cmd_irq();
    t_line();
    t_bar();
    t_reserved();
    t_caps();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule